// File: doc/BRIEF.md
# Link Training Pattern Inserter

This block decides, cycle by cycle, whether a transmit data path sends payload or a training sequence. A free-running interval counter measures transmit cycles since the last training sequence ended. Once it reaches its programmed maximum, training becomes due. Due training waits until the data scheduler signals a legal burst boundary, so a burst is never cut. It then sends a fixed number of training patterns, each twenty cycles long by default. The number of patterns comes from an 8-bit repetition count, and zero stands for 256.

Training is also forced whenever the far-end status path reports loss of sync. Such a run ignores the repetition count. It keeps repeating whole patterns until sync is back at the end of a pattern. A loss of sync at the end of an interval run extends that run in the same way. A return of sync in the middle of an interval run does not shorten it.

The outputs are a select to the output multiplexer, a strobe on the first word of every pattern, and the index of the current word within its pattern. The word contents and serialization belong to the logic downstream.

Top module: `link_train_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `train_sel`, `pat_strobe` and `word_idx` are all zero.
- R2: Interval training starts only through a cycle in which training is due and `burst_edge` is high. `train_sel` rises in the cycle after that one. While `burst_edge` stays low and sync is held, `train_sel` stays low, however long training has been due.
- R3: During training, `word_idx` steps 0, 1, ..., PAT_LEN-1 and then wraps to 0. `pat_strobe` is high exactly when `train_sel` is high and `word_idx` is 0.
- R4: An interval run with sync held keeps `train_sel` high for exactly N*PAT_LEN cycles, where N is the captured repetition count. `train_sel` falls in the cycle after the last word of the last pattern.
- R5: A captured repetition count of zero gives 256 patterns, that is 256*PAT_LEN cycles of training.
- R6: When `sync_ok` is low in a cycle without training, `train_sel` is high in the next cycle, whatever the interval and burst state.
- R7: A run started by loss of sync ends only after a last pattern word during which `sync_ok` is high. Such a run always lasts a whole number of patterns.
- R8: `rep_cnt` is captured while reset is asserted. Changes to it after reset do not change the run length.
- R9: With `burst_edge` held high and sync held, training is due after IVL_MAX idle cycles. Counting starts at reset or at the last training cycle. `train_sel` then stays low for IVL_MAX cycles between runs, counted from the first cycle after reset or after a run's first low cycle.
- R10: If sync is lost and regained inside an interval run, before its last pattern ends, the run still lasts N*PAT_LEN cycles.
- R11: If `sync_ok` is low at the last word of an interval run's last pattern, training goes on in whole patterns until a pattern ends with `sync_ok` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high; also captures `rep_cnt` |
| rep_cnt | input | 8 | Patterns per interval run; 0 means 256 |
| sync_ok | input | 1 | Far-end status path is in sync (high) |
| burst_edge | input | 1 | Scheduler is at a legal burst boundary this cycle |
| train_sel | output | 1 | Output multiplexer selects training words |
| pat_strobe | output | 1 | First word of a training pattern |
| word_idx | output | $clog2(PAT_LEN) | Word position within the current pattern |

## Verification
The bench builds the block with the default pattern length of 20 and an interval maximum of 50 instead of thousands of cycles. This puts many interval runs within a short simulation, along with the gap between them and the deferral behind a held-low burst boundary. The short interval also makes room for a full 256-pattern run, from a zero count, alongside the sync-loss cases. Those cases cover a loss that starts while idle, a loss and return inside an interval run, and a loss held across the end of its last pattern.

// File: rtl/link_train_gate.sv
module link_train_gate #(
  parameter int PAT_LEN = 20,
  parameter int IVL_MAX = 4096,
  parameter int REP_W   = 8,
  localparam int POS_W  = $clog2(PAT_LEN),
  localparam int IVL_W  = $clog2(IVL_MAX + 1),
  localparam int CNT_W  = REP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REP_W-1:0] rep_cnt,
  input  logic             sync_ok,
  input  logic             burst_edge,
  output logic             train_sel,
  output logic             pat_strobe,
  output logic [POS_W-1:0] word_idx
);

  logic [REP_W-1:0] rep_q;
  logic [CNT_W-1:0] reps_left;
  logic [IVL_W-1:0] ivl;
  logic             train;
  logic [POS_W-1:0] pos;

  wire             due      = (ivl == IVL_W'(IVL_MAX));
  wire [CNT_W-1:0] rep_eff  = (rep_q == '0) ? {1'b1, {REP_W{1'b0}}} : {1'b0, rep_q};
  wire             pat_end  = train && (pos == POS_W'(PAT_LEN - 1));
  wire             more     = (reps_left > CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q     <= rep_cnt;
      train     <= 1'b0;
      pos       <= '0;
      reps_left <= '0;
      ivl       <= '0;
    end else if (!train) begin
      if (!sync_ok) begin
        train     <= 1'b1;
        pos       <= '0;
        reps_left <= '0;
      end else if (due && burst_edge) begin
        train     <= 1'b1;
        pos       <= '0;
        reps_left <= rep_eff;
      end else if (!due) begin
        ivl <= ivl + 1'b1;
      end
    end else if (pat_end) begin
      pos <= '0;
      if (more)
        reps_left <= reps_left - 1'b1;
      else if (!sync_ok)
        reps_left <= '0;
      else begin
        train <= 1'b0;
        ivl   <= '0;
      end
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign train_sel  = train;
  assign pat_strobe = train && (pos == '0);
  assign word_idx   = pos;

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!train_sel && !pat_strobe && word_idx == '0));

  a_r2_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(train_sel) |-> ($past(!sync_ok) || $past(burst_edge)));

  a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
    (train_sel && $past(train_sel) && !$past(rst)) |->
      (word_idx == (($past(word_idx) == POS_W'(PAT_LEN - 1)) ? '0 : $past(word_idx) + 1'b1)));

  a_r6_sync_loss_start: assert property (@(posedge clk) disable iff (rst)
    (!train_sel && !sync_ok) |=> train_sel);

  a_r7_end_on_pattern_with_sync: assert property (@(posedge clk) disable iff (rst)
    $fell(train_sel) |-> ($past(word_idx) == POS_W'(PAT_LEN - 1) && $past(sync_ok)));

  a_r9_interval_due: assert property (@(posedge clk) disable iff (rst)
    ($rose(train_sel) && $past(sync_ok)) |-> $past(ivl) == IVL_W'(IVL_MAX));

endmodule

// File: tb/link_train_gate_bench.sv
module link_train_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PAT = 20;
  localparam int IVL = 50;
  localparam int PW  = $clog2(PAT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rep_cnt = 8'd3;
  logic sync_ok = 1'b1;
  logic burst_edge = 1'b1;
  logic train_sel, pat_strobe;
  logic [PW-1:0] word_idx;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  link_train_gate #(.PAT_LEN(PAT), .IVL_MAX(IVL)) u_link_train_gate (
    .clk(clk), .rst(rst), .rep_cnt(rep_cnt), .sync_ok(sync_ok),
    .burst_edge(burst_edge), .train_sel(train_sel),
    .pat_strobe(pat_strobe), .word_idx(word_idx));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: m_left = patterns still owed, -1 while sync-driven
  int  m_rep = 3, m_k = 0, m_left = 0, m_wait = 0;
  bit  m_on = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_rep  = (rep_cnt == 0) ? 256 : int'(rep_cnt);
      m_on   = 1'b0; m_k = 0; m_left = 0; m_wait = 0;
    end else if (!m_on) begin
      if (!sync_ok) begin m_on = 1'b1; m_k = 0; m_left = -1; end
      else if (m_wait >= IVL && burst_edge) begin m_on = 1'b1; m_k = 0; m_left = m_rep; end
      else m_wait++;
    end else if (m_k == PAT - 1) begin
      m_k = 0;
      if (m_left > 1) m_left--;
      else if (!sync_ok) m_left = -1;
      else begin m_on = 1'b0; m_wait = 0; end
    end else m_k++;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(train_sel == m_on, "R4 train_sel vs model", int'(train_sel), int'(m_on));
      check(int'(word_idx) == (m_on ? m_k : 0), "R3 word_idx vs model", int'(word_idx), m_on ? m_k : 0);
      check(pat_strobe == (m_on && m_k == 0), "R3 pat_strobe vs model", int'(pat_strobe), int'(m_on && m_k == 0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset(input logic [7:0] rep);
    @(negedge clk);
    rst = 1'b1; rep_cnt = rep;
    repeat (3) @(negedge clk);
    check(!train_sel && !pat_strobe && word_idx == '0, "R1 outputs during reset",
          int'(train_sel), 0);
    rst = 1'b0;
  endtask

  task automatic gap(output int g);
    g = 0;
    @(negedge clk);
    while (!train_sel) begin g++; @(negedge clk); end
  endtask

  task automatic run(input int lo, input int hi, output int len);
    len = 0;
    while (train_sel) begin
      if (len == lo) sync_ok = 1'b0;
      if (len == hi) sync_ok = 1'b1;
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int g, len, hi_seen;
    // R9 and R4: interval runs of 3 patterns
    sync_ok = 1'b1; burst_edge = 1'b1;
    do_reset(8'd3);
    gap(g);     check(g == IVL, "R9 first gap", g, IVL);
    run(-1, -1, len); check(len == 3*PAT, "R4 run length rep=3", len, 3*PAT);
    g = 0; while (!train_sel) begin g++; @(negedge clk); end
    check(g == IVL + 1, "R9 gap between runs", g, IVL + 1);
    run(-1, -1, len); check(len == 3*PAT, "R4 second run", len, 3*PAT);

    // R2: deferral until burst boundary
    burst_edge = 1'b0;
    do_reset(8'd2);
    hi_seen = 0;
    repeat (IVL + 30) begin @(negedge clk); if (train_sel) hi_seen++; end
    check(hi_seen == 0, "R2 no training without boundary", hi_seen, 0);
    burst_edge = 1'b1;
    @(negedge clk);
    burst_edge = 1'b0;
    check(train_sel == 1'b1, "R2 start after boundary", int'(train_sel), 1);
    run(-1, -1, len); check(len == 2*PAT, "R4 deferred run length", len, 2*PAT);

    // R6 and R7: sync loss while idle, 35 cycles low
    @(negedge clk);
    sync_ok = 1'b0;
    gap(g);   check(g == 0, "R6 immediate start", g, 0);
    run(-1, 34, len); check(len == 2*PAT, "R7 sync run whole patterns", len, 2*PAT);

    // R10: sync dips inside an interval run
    burst_edge = 1'b1;
    do_reset(8'd2);
    gap(g);
    run(5, 10, len); check(len == 2*PAT, "R10 run keeps count", len, 2*PAT);

    // R11: sync low across last pattern end
    gap(g);
    run(35, 55, len); check(len == 3*PAT, "R11 extended run", len, 3*PAT);

    // R8: rep_cnt change after reset ignored
    do_reset(8'd1);
    rep_cnt = 8'd5;
    gap(g);
    run(-1, -1, len); check(len == PAT, "R8 count held from reset", len, PAT);
    gap(g);
    run(-1, -1, len); check(len == PAT, "R8 second run", len, PAT);

    // R5: zero means 256
    do_reset(8'd0);
    gap(g);
    run(-1, -1, len); check(len == 256*PAT, "R5 zero count", len, 256*PAT);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule